// File: doc/BRIEF.md
# Second-Order All-Pole Recursive Filter Section

This block is a streaming, causal recursive filter with two poles and no feed-forward taps. For every accepted input sample it produces one output sample, following y[n] = x[n] - a·y[n-1] - b·y[n-2]. The default coefficients are a = 1/2 and b = 1/9. The last two outputs sit in a two-slot delay line. The delay line is zero after reset, so the filter starts from rest.

Samples are signed Q1.15 values and coefficients are signed Q2.14 parameters. The three terms are summed at full precision. The sum is rounded to nearest, with ties toward plus infinity, and then clamped to the Q1.15 range. The result is registered and goes out one clock after the sample that produced it, together with a valid strobe. A synchronous clear returns the recursion to rest without a reset.

Top module: `iir2_pole_sect`

## Requirements
- R1: When a sample is accepted, the new output equals round((x·2^14 - A·y1 - B·y2) / 2^14). Here x, y1 and y2 are Q1.15 integers, y1 is the newest stored output and y2 the one before it. A = 8192 (a = 0.5) and B = 1820 (b ≈ 1/9) are Q2.14 integers by default.
- R2: Rounding adds 2^13 to the full-precision sum and then shifts it right arithmetically by 14 bits, so an exact half rounds toward plus infinity.
- R3: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R4: On each accepted sample the older slot takes the value of the newer slot, and the newer slot takes the new output.
- R5: y_valid_o is high in the cycle after x_valid_i is sampled high without clr_i. In that cycle y_o holds the new output.
- R6: After rst_ni is released, y_o is 0, y_valid_o is 0 and both delay slots are 0.
- R7: In a cycle with x_valid_i low and clr_i low, the delay line and y_o do not change, and y_valid_o is low in the next cycle.
- R8: clr_i is synchronous and takes priority over a sample in the same cycle. It zeros both slots and y_o, drops that sample, and y_valid_o is low in the next cycle.
- R9: Input 16384 (0.5) followed by zeros gives outputs within one LSB of 32768·0.5·h[n], where h[n] is the exact real recursion with a = 1/2 and b = 1/9. This holds for the first six outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the recursion state |
| x_valid_i | input | 1 | Input sample strobe |
| x_i | input | 16 | Input sample, signed Q1.15 |
| y_valid_o | output | 1 | Output sample strobe |
| y_o | output | 16 | Output sample, signed Q1.15 |

## Verification
A clear and an input sample can arrive in the same cycle. The bench provokes this twice: once while the delay line holds non-zero history, and once immediately after a saturating burst. A correct design must drop the sample and keep y_valid_o low in the next cycle. The following samples must then recurse from zero history. The cycle-accurate reference model checks all three conditions on every clock.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'b00,
    SAT_POS  = 2'b01,
    SAT_NEG  = 2'b10
  } sat_e;
endpackage

// File: rtl/iir2_mac.sv
module iir2_mac #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int COEF_A    = 8192,
  parameter int COEF_B    = 1820,
  parameter int ACC_W     = DATA_W + COEF_W + 2
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y1_i,
  input  logic signed [DATA_W-1:0] y2_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam logic signed [COEF_W-1:0] CA = COEF_W'(COEF_A);
  localparam logic signed [COEF_W-1:0] CB = COEF_W'(COEF_B);

  logic signed [ACC_W-1:0] x_ext, y1_ext, y2_ext, ca_ext, cb_ext;
  logic signed [ACC_W-1:0] x_al, p_a, p_b;

  always_comb begin
    x_ext  = ACC_W'(x_i);
    y1_ext = ACC_W'(y1_i);
    y2_ext = ACC_W'(y2_i);
    ca_ext = ACC_W'(CA);
    cb_ext = ACC_W'(CB);
    // align the input to the product binary point
    x_al   = x_ext <<< COEF_FRAC;
    p_a    = y1_ext * ca_ext;
    p_b    = y2_ext * cb_ext;
    acc_o  = x_al - p_a - p_b;
  end
endmodule

// File: rtl/iir2_round_sat.sv
module iir2_round_sat
  import iir2_pkg::*;
#(
  parameter int ACC_W  = 34,
  parameter int SHIFT  = 14,
  parameter int DATA_W = 16
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] y_o,
  output sat_e                     sat_o
);
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAX_V = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MIN_V = -MAX_V - ACC_W'(1);

  logic signed [ACC_W-1:0] rnd, shr;

  always_comb begin
    rnd = acc_i + HALF;
    shr = rnd >>> SHIFT;
    if (shr > MAX_V) begin
      sat_o = SAT_POS;
      y_o   = MAX_V[DATA_W-1:0];
    end else if (shr < MIN_V) begin
      sat_o = SAT_NEG;
      y_o   = MIN_V[DATA_W-1:0];
    end else begin
      sat_o = SAT_NONE;
      y_o   = shr[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/iir2_delay_line.sv
module iir2_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           adv_i,
  input  logic [DATA_W-1:0]              din_i,
  output logic [DEPTH-1:0][DATA_W-1:0]   taps_o
);
  // taps_o[0] newest, taps_o[DEPTH-1] oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    logic [DATA_W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = taps_o[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    taps_o[g] <= '0;
      else if (clr_i) taps_o[g] <= '0;
      else if (adv_i) taps_o[g] <= nxt;
    end

    if (g > 0) begin : g_chk
      AST_SHIFT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !clr_i) |=> taps_o[g] == $past(taps_o[g-1])); // R4
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> taps_o == '0); // R8
endmodule

// File: rtl/iir2_pole_sect.sv
module iir2_pole_sect
  import iir2_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int COEF_A    = 8192,
  parameter int COEF_B    = 1820
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     x_valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic                     y_valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int ACC_W = DATA_W + COEF_W + 2;
  localparam int DEPTH = 2;
  localparam logic signed [DATA_W-1:0] Y_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] Y_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DEPTH-1:0][DATA_W-1:0] taps;
  logic signed [ACC_W-1:0]      acc;
  logic signed [DATA_W-1:0]     y_new;
  sat_e                         sat;
  logic                         adv;

  assign adv = x_valid_i && !clr_i;

  iir2_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .COEF_A(COEF_A), .COEF_B(COEF_B), .ACC_W(ACC_W)
  ) u_mac (
    .x_i  (x_i),
    .y1_i (taps[0]),
    .y2_i (taps[1]),
    .acc_o(acc)
  );

  iir2_round_sat #(
    .ACC_W(ACC_W), .SHIFT(COEF_FRAC), .DATA_W(DATA_W)
  ) u_rs (
    .acc_i(acc),
    .y_o  (y_new),
    .sat_o(sat)
  );

  iir2_delay_line #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .adv_i (adv),
    .din_i (y_new),
    .taps_o(taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_valid_o <= 1'b0;
    else         y_valid_o <= adv;
  end

  assign y_o = taps[0];

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_valid_i && !clr_i) |=> y_valid_o); // R5
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!y_valid_o && y_o == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_valid_i && !clr_i) |=> (!y_valid_o && $stable(y_o))); // R7
  AST_SAT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sat == SAT_POS) |=> y_o == Y_MAX); // R3
  AST_SAT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sat == SAT_NEG) |=> y_o == Y_MIN); // R3
endmodule

// File: tb/iir2_pole_sect_bench.sv
module iir2_pole_sect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic xv = 1'b0;
  logic signed [15:0] x = '0;
  logic yv;
  logic signed [15:0] y;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint m1 = 0, m2 = 0, m_y = 0;
  bit m_v = 1'b0;

  always #4 clk = ~clk;

  iir2_pole_sect u_iir2_pole_sect (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .x_valid_i(xv), .x_i(x), .y_valid_o(yv), .y_o(y)
  );

  function automatic longint model_out(longint xs, longint p1, longint p2);
    longint acc, r;
    acc = xs * 16384 - 8192 * p1 - 1820 * p2;
    r = (acc + 8192) >>> 14;   // R2 round half up
    if (r > 32767) r = 32767;  // R3
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, pass posedge, update model, compare at next negedge
  task automatic cyc(bit v, int xs, bit c, string tag);
    xv = v; x = 16'(xs); clr = c;
    @(posedge clk);
    if (c) begin
      m1 = 0; m2 = 0; m_y = 0; m_v = 1'b0;
    end else if (v) begin
      m_y = model_out(xs, m1, m2);
      m2 = m1; m1 = m_y; m_v = 1'b1;
    end else begin
      m_v = 1'b0;
    end
    @(negedge clk);
    check({tag, " valid"}, longint'(yv), longint'(m_v));
    check({tag, " data"}, longint'(y), m_y);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset valid", longint'(yv), 0);
    check("R6 reset data", longint'(y), 0);

    // R1 R4 R5: general recursion, varied patterns
    cyc(1, 12000, 0, "R1 step");
    cyc(1, -7000, 0, "R1 step");
    cyc(1, 300, 0, "R4 order");
    cyc(1, 0, 0, "R4 order");
    cyc(1, -20000, 0, "R5 stream");
    cyc(1, 9999, 0, "R5 stream");
    // R7 idle gaps hold state
    cyc(0, 31000, 0, "R7 idle");
    cyc(0, -31000, 0, "R7 idle");
    cyc(1, 1234, 0, "R7 resume");
    // R8 clear collides with a sample
    cyc(1, 25000, 1, "R8 clear+sample");
    cyc(1, 1, 0, "R8 from rest");
    // R2 tie: y1=1, y2=0 gives exact -0.5 term
    cyc(1, 5, 0, "R2 tie");
    cyc(1, -3, 0, "R2 round");
    // R3 alternating full scale drives saturation
    for (int i = 0; i < 8; i++)
      cyc(1, (i % 2 == 0) ? 32767 : -32768, 0, "R3 sat");
    cyc(1, -100, 1, "R8 clear after sat");
    cyc(0, 0, 0, "R7 idle after clear");
    // R9 impulse against real recursion
    begin
      real r1, r2, rn;
      r1 = 0.0; r2 = 0.0;
      for (int n = 0; n < 6; n++) begin
        cyc(1, (n == 0) ? 16384 : 0, 0, "R9 impulse model");
        rn = ((n == 0) ? 0.5 : 0.0) - 0.5 * r1 - r2 / 9.0;
        r2 = r1; r1 = rn;
        checks++;
        if ((real'(y) - rn * 32768.0) > 1.0 || (rn * 32768.0 - real'(y)) > 1.0) begin
          fails++;
          $display("FAIL R9 impulse actual=%0d expected=%0f", y, rn * 32768.0);
        end
      end
    end
    cyc(1, -32768, 0, "R1 neg full");
    cyc(1, 32767, 0, "R1 pos full");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule